// File: doc/BRIEF.md
# Serial Audio Link Frame Slot Deserializer

This block observes a serial audio codec link: one frame marker line and two data lines, one for each direction, all timed by the link bit clock. It samples every line on the falling edge of that clock. It locates the start of each frame from a low-to-high transition of the marker, counts the bits of the frame and gathers them into per-slot words, most significant bit first.

A frame carries 256 bits. It opens with a 16-bit tag slot, which is followed by twelve 20-bit slots. Each time a slot finishes, the block raises a one-cycle strobe for that direction and presents the slot number, the slot width and the slot value. Any bit that arrives after the last bit of a frame is discarded until the marker rises again. A marker rise in the middle of a frame discards the partly gathered slot and starts the count again.

The two data directions are handled side by side. A parameter removes either lane when that data line is absent from the system. The block interprets no slot contents and never drives the link.

Top module: `ac_link_deser`

## Requirements
- R1: All inputs are sampled on the falling edge of `link_clk`. A frame start occurs when `link_sync` is sampled low on one falling edge and high on the next. The data bit sampled on the falling edge after that becomes bit 0 of the frame.
- R2: Slot 0 is 16 bits wide and slots 1 to 12 are 20 bits wide. Every strobe reports a length of 16 for index 0 and 20 for any other index.
- R3: Slot bits are gathered MSB first: the first bit received lands in the most significant position of the slot value. The 16-bit slot 0 value is right-aligned, so value bits 19..16 read zero.
- R4: Each completed slot gives exactly one single-cycle strobe per direction, with the 4-bit slot index. Index, length and value update on the same falling edge that samples the slot's final bit, and the slots of a frame appear in order 0 to 12.
- R5: Bits sampled after frame bit 255 and before the next frame start produce no strobe.
- R6: A frame start in the middle of a frame discards the partial slot and restarts the count at bit 0 of slot 0.
- R7: Synchronous active-high reset clears the block to a no-frame-seen state, with strobes low and values zero. No strobe is issued until the first frame start.
- R8: The output lane and the input lane run in parallel from the same frame count. A lane removed by its parameter (`HAS_OUT` or `HAS_IN` = 0) holds its strobe, index, length and value at zero.
- R9: A marker that stays high for many bits counts as one frame start only. A new start needs a sampled low followed by a sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| link_clk | input | 1 | Link bit clock; everything is sampled on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| link_sync | input | 1 | Frame marker line |
| link_sdo | input | 1 | Controller-to-codec serial data |
| link_sdi | input | 1 | Codec-to-controller serial data |
| out_vld | output | 1 | Slot-complete strobe, output direction |
| out_idx | output | 4 | Slot number, output direction |
| out_len | output | 5 | Slot width in bits, output direction |
| out_val | output | 20 | Slot value, right-aligned, output direction |
| in_vld | output | 1 | Slot-complete strobe, input direction |
| in_idx | output | 4 | Slot number, input direction |
| in_len | output | 5 | Slot width in bits, input direction |
| in_val | output | 20 | Slot value, right-aligned, input direction |

## Verification
The assertions check several properties on every cycle:
- A strobe always carries the length that matches its index.
- The tag value leaves its upper bits clear.
- Strobes never last two cycles.
- A marker held high never starts a second frame.
- A frame start always leaves the counter at bit 1 of slot 0.
- No bit is taken outside a running frame.

Some behaviour only the bench scenarios can show: the exact falling edge at which each slot value appears, the MSB-first value contents, the dropping of trailing bits, the abandonment of a cut-short frame, and an absent lane that stays silent while the other lane still decodes.

// File: rtl/ac_link_pkg.sv
package ac_link_pkg;

    localparam int DEF_TAG_BITS  = 16;
    localparam int DEF_SLOT_BITS = 20;
    localparam int DEF_SLOTS     = 13;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

    function automatic int slot_width(int idx, int tag_bits, int slot_bits);
        return (idx == 0) ? tag_bits : slot_bits;
    endfunction

endpackage

// File: rtl/ac_link_sync_detect.sv
module ac_link_sync_detect (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    output logic start_o
);
    logic sync_q;
    logic start_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            sync_q  <= 1'b1;
            start_q <= 1'b0;
        end else begin
            sync_q  <= sync_i;
            start_q <= sync_i & ~sync_q;
        end
    end

    assign start_o = start_q;

    // R9
    single_start_chk: assert property (@(negedge clk) disable iff (rst)
        start_q |=> !start_q);

endmodule

// File: rtl/ac_link_slot_seq.sv
module ac_link_slot_seq
    import ac_link_pkg::*;
#(
    parameter int TAG_BITS  = DEF_TAG_BITS,
    parameter int SLOT_BITS = DEF_SLOT_BITS,
    parameter int SLOTS     = DEF_SLOTS,
    localparam int IDX_W    = $clog2(SLOTS),
    localparam int SB_W     = $clog2(SLOT_BITS),
    localparam int LEN_W    = $clog2(SLOT_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             take_o,
    output logic             first_o,
    output logic             last_o,
    output logic [IDX_W-1:0] slot_o,
    output logic [LEN_W-1:0] len_o
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOTS - 1);

    seq_state_e       state_q;
    logic [IDX_W-1:0] slot_q;
    logic [SB_W-1:0]  sbit_q;
    logic [IDX_W-1:0] cur_slot;
    logic [SB_W-1:0]  cur_bit;
    logic [SB_W-1:0]  cur_top;

    always_comb begin
        take_o   = 1'b0;
        cur_slot = slot_q;
        cur_bit  = sbit_q;
        if (start_i) begin
            take_o   = 1'b1;
            cur_slot = '0;
            cur_bit  = '0;
        end else if (state_q == SEQ_RUN) begin
            take_o = 1'b1;
        end
        cur_top = SB_W'(slot_width(int'(cur_slot), TAG_BITS, SLOT_BITS) - 1);
        first_o = (cur_bit == '0);
        last_o  = (cur_bit == cur_top);
        slot_o  = cur_slot;
        len_o   = LEN_W'(slot_width(int'(cur_slot), TAG_BITS, SLOT_BITS));
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            slot_q  <= '0;
            sbit_q  <= '0;
        end else if (take_o) begin
            if (last_o) begin
                sbit_q <= '0;
                if (cur_slot == LAST_SLOT) begin
                    state_q <= SEQ_DONE;
                    slot_q  <= '0;
                end else begin
                    state_q <= SEQ_RUN;
                    slot_q  <= cur_slot + 1'b1;
                end
            end else begin
                state_q <= SEQ_RUN;
                slot_q  <= cur_slot;
                sbit_q  <= cur_bit + 1'b1;
            end
        end
    end

    // R6
    restart_pos_chk: assert property (@(negedge clk) disable iff (rst)
        start_i |=> (state_q == SEQ_RUN && slot_q == '0 && sbit_q == SB_W'(1)));

    // R5
    no_take_outside_chk: assert property (@(negedge clk) disable iff (rst)
        (state_q != SEQ_RUN && !start_i) |-> !take_o);

    // R2
    bit_in_range_chk: assert property (@(negedge clk) disable iff (rst)
        (state_q == SEQ_RUN) |->
            (int'(sbit_q) < slot_width(int'(slot_q), TAG_BITS, SLOT_BITS)));

endmodule

// File: rtl/ac_link_lane.sv
module ac_link_lane
    import ac_link_pkg::*;
#(
    parameter int TAG_BITS  = DEF_TAG_BITS,
    parameter int SLOT_BITS = DEF_SLOT_BITS,
    parameter int IDX_W     = 4,
    parameter int LEN_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take_i,
    input  logic                 first_i,
    input  logic                 last_i,
    input  logic [IDX_W-1:0]     slot_i,
    input  logic [LEN_W-1:0]     len_i,
    input  logic                 bit_i,
    output logic                 vld_o,
    output logic [IDX_W-1:0]     idx_o,
    output logic [LEN_W-1:0]     len_o,
    output logic [SLOT_BITS-1:0] val_o
);
    logic [SLOT_BITS-1:0] shift_q;
    logic [SLOT_BITS-1:0] shift_nxt;

    always_comb begin
        if (first_i) shift_nxt = {{(SLOT_BITS-1){1'b0}}, bit_i};
        else         shift_nxt = {shift_q[SLOT_BITS-2:0], bit_i};
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            shift_q <= '0;
            vld_o   <= 1'b0;
            idx_o   <= '0;
            len_o   <= '0;
            val_o   <= '0;
        end else begin
            vld_o <= take_i & last_i;
            if (take_i) shift_q <= shift_nxt;
            if (take_i && last_i) begin
                idx_o <= slot_i;
                len_o <= len_i;
                val_o <= shift_nxt;
            end
        end
    end

    // R4
    strobe_pulse_chk: assert property (@(negedge clk) disable iff (rst)
        vld_o |=> !vld_o);

    // R2
    len_match_chk: assert property (@(negedge clk) disable iff (rst)
        vld_o |-> (int'(len_o) == slot_width(int'(idx_o), TAG_BITS, SLOT_BITS)));

    // R3
    tag_aligned_chk: assert property (@(negedge clk) disable iff (rst)
        (vld_o && idx_o == '0) |-> (val_o >> TAG_BITS) == '0);

endmodule

// File: rtl/ac_link_deser.sv
module ac_link_deser
    import ac_link_pkg::*;
#(
    parameter int  TAG_BITS  = DEF_TAG_BITS,
    parameter int  SLOT_BITS = DEF_SLOT_BITS,
    parameter int  SLOTS     = DEF_SLOTS,
    parameter bit  HAS_OUT   = 1'b1,
    parameter bit  HAS_IN    = 1'b1,
    localparam int IDX_W     = $clog2(SLOTS),
    localparam int LEN_W     = $clog2(SLOT_BITS + 1)
) (
    input  logic                 link_clk,
    input  logic                 rst,
    input  logic                 link_sync,
    input  logic                 link_sdo,
    input  logic                 link_sdi,
    output logic                 out_vld,
    output logic [IDX_W-1:0]     out_idx,
    output logic [LEN_W-1:0]     out_len,
    output logic [SLOT_BITS-1:0] out_val,
    output logic                 in_vld,
    output logic [IDX_W-1:0]     in_idx,
    output logic [LEN_W-1:0]     in_len,
    output logic [SLOT_BITS-1:0] in_val
);
    logic             start;
    logic             take;
    logic             first;
    logic             last;
    logic [IDX_W-1:0] slot;
    logic [LEN_W-1:0] len;

    ac_link_sync_detect u_sync (
        .clk     (link_clk),
        .rst     (rst),
        .sync_i  (link_sync),
        .start_o (start)
    );

    ac_link_slot_seq #(
        .TAG_BITS  (TAG_BITS),
        .SLOT_BITS (SLOT_BITS),
        .SLOTS     (SLOTS)
    ) u_seq (
        .clk     (link_clk),
        .rst     (rst),
        .start_i (start),
        .take_o  (take),
        .first_o (first),
        .last_o  (last),
        .slot_o  (slot),
        .len_o   (len)
    );

    generate
        if (HAS_OUT) begin : g_out
            ac_link_lane #(
                .TAG_BITS (TAG_BITS), .SLOT_BITS (SLOT_BITS),
                .IDX_W (IDX_W), .LEN_W (LEN_W)
            ) u_lane (
                .clk (link_clk), .rst (rst), .take_i (take), .first_i (first),
                .last_i (last), .slot_i (slot), .len_i (len), .bit_i (link_sdo),
                .vld_o (out_vld), .idx_o (out_idx), .len_o (out_len), .val_o (out_val)
            );
        end else begin : g_no_out
            assign out_vld = 1'b0;
            assign out_idx = '0;
            assign out_len = '0;
            assign out_val = '0;
        end

        if (HAS_IN) begin : g_in
            ac_link_lane #(
                .TAG_BITS (TAG_BITS), .SLOT_BITS (SLOT_BITS),
                .IDX_W (IDX_W), .LEN_W (LEN_W)
            ) u_lane (
                .clk (link_clk), .rst (rst), .take_i (take), .first_i (first),
                .last_i (last), .slot_i (slot), .len_i (len), .bit_i (link_sdi),
                .vld_o (in_vld), .idx_o (in_idx), .len_o (in_len), .val_o (in_val)
            );
        end else begin : g_no_in
            assign in_vld = 1'b0;
            assign in_idx = '0;
            assign in_len = '0;
            assign in_val = '0;
        end
    endgenerate

    // R8
    lanes_aligned_chk: assert property (@(negedge link_clk) disable iff (rst)
        (HAS_OUT && HAS_IN) |-> (out_vld == in_vld));

endmodule

// File: tb/ac_link_deser_bench.sv
module ac_link_deser_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_sync = 1'b0;
    logic link_sdo = 1'b0;
    logic link_sdi = 1'b0;

    logic        out_vld, in_vld;
    logic [3:0]  out_idx, in_idx;
    logic [4:0]  out_len, in_len;
    logic [19:0] out_val, in_val;

    logic        n_out_vld, n_in_vld;
    logic [3:0]  n_out_idx, n_in_idx;
    logic [4:0]  n_out_len, n_in_len;
    logic [19:0] n_out_val, n_in_val;

    always #5 clk = ~clk;

    ac_link_deser u_ac_link_deser (
        .link_clk (clk), .rst (rst), .link_sync (link_sync),
        .link_sdo (link_sdo), .link_sdi (link_sdi),
        .out_vld (out_vld), .out_idx (out_idx), .out_len (out_len), .out_val (out_val),
        .in_vld (in_vld), .in_idx (in_idx), .in_len (in_len), .in_val (in_val)
    );

    ac_link_deser #(.HAS_IN(1'b0)) u_ac_link_deser_noin (
        .link_clk (clk), .rst (rst), .link_sync (link_sync),
        .link_sdo (link_sdo), .link_sdi (link_sdi),
        .out_vld (n_out_vld), .out_idx (n_out_idx), .out_len (n_out_len), .out_val (n_out_val),
        .in_vld (n_in_vld), .in_idx (n_in_idx), .in_len (n_in_len), .in_val (n_in_val)
    );

    int checks = 0;
    int errors = 0;
    int ncnt = 0;
    int main_strobes = 0;
    int noin_strobes = 0;
    bit noin_in_seen = 0;

    typedef struct {
        int idx;
        int len;
        int val;
        int due;
    } item_t;

    item_t q_out[$];
    item_t q_in[$];

    // reference frame model, built from the requirements
    bit   m_prev = 1'b1;
    bit   m_pend = 1'b0;
    bit   m_act  = 1'b0;
    int   m_pos  = 0;
    logic [19:0] m_sh_o = '0;
    logic [19:0] m_sh_i = '0;
    logic [31:0] lf = 32'h1ACE_B00C;

    always @(negedge clk) ncnt <= ncnt + 1;

    function automatic bit rnd_bit();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        return lf[0];
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic drive_bit(input bit s, input bit o, input bit i);
        @(posedge clk);
        link_sync <= s;
        link_sdo  <= o;
        link_sdi  <= i;
        if (m_pend) begin
            m_act = 1'b1;
            m_pos = 0;
        end
        if (m_act && m_pos < 256) begin
            int sl, b, w;
            if (m_pos < 16) begin
                sl = 0; b = m_pos; w = 16;
            end else begin
                sl = 1 + (m_pos - 16) / 20; b = (m_pos - 16) % 20; w = 20;
            end
            m_sh_o = (b == 0) ? {19'd0, o} : {m_sh_o[18:0], o};
            m_sh_i = (b == 0) ? {19'd0, i} : {m_sh_i[18:0], i};
            if (b == w - 1) begin
                q_out.push_back('{sl, w, int'(m_sh_o), ncnt + 1});
                q_in.push_back('{sl, w, int'(m_sh_i), ncnt + 1});
            end
            m_pos++;
        end
        m_pend = s && !m_prev;
        m_prev = s;
    endtask

    // one idle low bit, a marker lead bit, then nbits frame bits;
    // the marker stays high for sync_hi bit times in total
    task automatic send_frame(input int nbits, input int sync_hi,
                              input logic [15:0] tag_o, input logic [15:0] tag_i);
        drive_bit(1'b0, rnd_bit(), rnd_bit());
        drive_bit(1'b1, rnd_bit(), rnd_bit());
        for (int k = 0; k < nbits; k++) begin
            bit s, o, i;
            s = (k < sync_hi - 1);
            if (k < 16) begin
                o = tag_o[15 - k];
                i = tag_i[15 - k];
            end else begin
                o = rnd_bit();
                i = rnd_bit();
            end
            drive_bit(s, o, i);
        end
    endtask

    task automatic cmp_item(input string dir, input item_t e, input int idx,
                            input int len, input int val);
        checks++;
        if (e.idx != idx || e.len != len || e.val != val || e.due != ncnt) begin
            errors++;
            $display("FAIL R4/%s idx %0d exp %0d | R2 len %0d exp %0d | R3 val %05h exp %05h | R1 edge %0d exp %0d",
                     dir, idx, e.idx, len, e.len, val, e.val, ncnt, e.due);
        end
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        if (!rst) begin
            if (q_out.size() > 0 && q_out[0].due < ncnt && !out_vld) begin
                item_t e;
                e = q_out.pop_front();
                checks++; errors++;
                $display("FAIL R4 out missing strobe got none exp idx %0d", e.idx);
            end
            if (q_in.size() > 0 && q_in[0].due < ncnt && !in_vld) begin
                item_t e;
                e = q_in.pop_front();
                checks++; errors++;
                $display("FAIL R4 in missing strobe got none exp idx %0d", e.idx);
            end
            if (out_vld) begin
                main_strobes++;
                if (q_out.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R5 out unexpected strobe got idx %0d exp none", out_idx);
                end else begin
                    cmp_item("out", q_out.pop_front(), int'(out_idx), int'(out_len), int'(out_val));
                end
            end
            if (in_vld) begin
                if (q_in.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R5 in unexpected strobe got idx %0d exp none", in_idx);
                end else begin
                    cmp_item("in", q_in.pop_front(), int'(in_idx), int'(in_len), int'(in_val));
                end
            end
            if (n_out_vld) noin_strobes++;
            if (n_in_vld || n_in_val != 0) noin_in_seen = 1'b1;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got timeout exp completion");
        finish_run();
    end

    initial begin : stim
        repeat (4) @(posedge clk);
        rst <= 1'b0;
        @(posedge clk);
        @(posedge clk);
        // R7: reset state
        checks++;
        if (out_vld !== 1'b0 || in_vld !== 1'b0 || out_val !== 20'd0 || in_idx !== 4'd0) begin
            errors++;
            $display("FAIL R7 reset state got vld %b/%b val %05h exp 0/0 00000", out_vld, in_vld, out_val);
        end
        // R7: noise before any frame start gives no strobe
        for (int k = 0; k < 20; k++) drive_bit(1'b0, rnd_bit(), rnd_bit());
        // R1 R2 R3 R4: full frame, tag all ones to show right alignment
        send_frame(256, 16, 16'hFFFF, 16'h8001);
        // R5: trailing bits after the frame are dropped
        for (int k = 0; k < 30; k++) drive_bit(1'b0, rnd_bit(), rnd_bit());
        // R6: frame cut short in slot 4, then restarted
        send_frame(90, 16, 16'h1234, 16'hA5C3);
        // R9: marker held high for 60 bits inside a frame
        send_frame(256, 60, 16'h0F0F, 16'hF0F0);
        // back-to-back frame with no trailing bits
        send_frame(256, 1, 16'h7FFE, 16'h0000);
        for (int k = 0; k < 12; k++) drive_bit(1'b0, rnd_bit(), rnd_bit());
        repeat (3) @(posedge clk);
        // R4: every expected strobe was seen
        checks++;
        if (q_out.size() != 0 || q_in.size() != 0) begin
            errors++;
            $display("FAIL R4 leftover items got %0d/%0d exp 0/0", q_out.size(), q_in.size());
        end
        // R8: absent input lane stays silent
        checks++;
        if (noin_in_seen) begin
            errors++;
            $display("FAIL R8 absent lane active got 1 exp 0");
        end
        // R8: remaining lane of the reduced block still decodes every slot
        checks++;
        if (noin_strobes != main_strobes || main_strobes == 0) begin
            errors++;
            $display("FAIL R8 out strobes got %0d exp %0d", noin_strobes, main_strobes);
        end
        finish_run();
    end

endmodule